// File: doc/BRIEF.md
# Pipelined CORDIC Rotator

This block turns a plane vector by an arbitrary angle using only adds, subtracts and fixed wired shifts. It is a fully unrolled pipeline: every clock it can take a new sample made of an x/y pair and an angle, and after a fixed delay it returns the turned vector. The result carries the usual CORDIC gain A, the product over all iteration stages of sqrt(1 + 2^-2i), which is about 1.647. To get cosine and sine directly, the caller seeds x with round((2^(DW-1)-1)/A) and y with zero. The outputs then come out as the full-scale cosine and sine, and no multiplier is needed afterwards.

The angle is a binary fraction of a full turn. An input stage folds any angle into the half turn the iterations can reach, by moving it half a turn when needed, and remembers that it did so. One register stage per iteration follows. Each of these stages uses a shift distance and an arctangent constant fixed at elaboration. A final stage rounds the result and undoes the fold by negating both outputs. A valid flag travels beside every sample.

Both edges of the block are valid-only streams. There is no ready signal and no back-pressure: a sample with in_valid high is always taken, and the consumer must take each result in the cycle where out_valid is high. A synchronous reset drops all samples in flight.

Top module: `cordic_rot_pipe`

## Requirements
- R1: A sample presented with in_valid high on a clock edge appears with out_valid high exactly LATENCY = STAGES + 2 cycles later, and results keep the order of their inputs.
- R2: A sample is accepted on every cycle with in_valid high, with no gaps needed, so a continuous stream produces one result per cycle.
- R3: With a signed input vector (x, y) and angle t, out_x is within 2 LSB of A·(x·cos t − y·sin t) and out_y is within 2 LSB of A·(x·sin t + y·cos t), where A is the product over i = 0..STAGES−1 of sqrt(1 + 2^-2i).
- R4: in_angle is two's complement with 2^AW counts per full turn, so 2^(AW-2) is +90 degrees and −2^(AW-1) is −180 degrees. Every code in all four quadrants meets R3, including the exact ±90 degree and −180 degree codes.
- R5: With x = round((2^(DW-1)−1)/A) and y = 0, out_x and out_y are (2^(DW-1)−1)·cos t and (2^(DW-1)−1)·sin t within 2 LSB.
- R6: While reset is high at a clock edge, out_valid is low in the following cycle. Samples in flight at reset never come out, and out_valid stays low for LATENCY cycles after reset unless new samples are given.
- R7: A cycle with in_valid low yields a cycle with out_valid low LATENCY cycles later, so bubbles are kept in place.
- R8: The DW+2 bit outputs hold the result for any input pair, including the full-scale corners such as (−2^(DW-1), −2^(DW-1)), with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears valid flags |
| in_valid | input | 1 | Input sample present |
| in_x | input | DW | Signed x of the vector to turn |
| in_y | input | DW | Signed y of the vector to turn |
| in_angle | input | AW | Turn angle, two's complement fraction of a full turn |
| out_valid | output | 1 | Result present |
| out_x | output | DW+2 | Signed x of the turned vector, gain A included |
| out_y | output | DW+2 | Signed y of the turned vector, gain A included |

## Verification
The bench builds the block with DW = 12, AW = 14 and STAGES = 14, which gives a latency of 16 cycles. With these values a full turn is 16384 angle codes, so sweeping every quadrant and hitting the exact quarter-turn and half-turn codes takes only a few dozen samples. At this size the 2 LSB error budget is also tight enough that a wrong constant, shift or sign stands out. The bench feeds a behavioural model that delays expected values in queues and compares every cycle, covering continuous streams, random bubbles, full-scale corner vectors and a reset in mid-stream.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

  localparam real TURN_RAD = 6.283185307179586;

  // Arctangent of 2^-idx expressed in units of 2^-zw of a full turn.
  function automatic int atan_code(input int idx, input int zw);
    real r;
    r = $atan(2.0 ** (-idx)) / TURN_RAD * (2.0 ** zw);
    return $rtoi(r + 0.5);
  endfunction

  // Extra fractional bits kept inside the datapath.
  function automatic int guard_bits(input int stages);
    return $clog2(stages) + 2;
  endfunction

  function automatic longint zabs(input longint v);
    return (v < 0) ? -v : v;
  endfunction

endpackage

// File: rtl/cordic_fold.sv
module cordic_fold
  import cordic_rot_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int IW = 24,
  parameter int ZW = 22
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_x,
  input  logic signed [DW-1:0] in_y,
  input  logic        [AW-1:0] in_angle,
  output logic                 v_o,
  output logic                 f_o,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  localparam int G  = IW - DW - 2;
  localparam int ZG = ZW - AW;

  logic          flip;
  logic [AW-1:0] folded;

  // Angles in the second or third quadrant have differing top bits.
  // Adding half a turn to them only flips the top bit, which then equals
  // the next bit, so the folded angle always lies in [-90, +90) degrees.
  always_comb begin
    flip   = in_angle[AW-1] ^ in_angle[AW-2];
    folded = {in_angle[AW-2], in_angle[AW-2:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= in_valid;
    f_o <= flip;
    x_o <= {{2{in_x[DW-1]}}, in_x, {G{1'b0}}};
    y_o <= {{2{in_y[DW-1]}}, in_y, {G{1'b0}}};
    z_o <= {folded, {ZG{1'b0}}};
  end

  AST_FOLD_HALF_TURN: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (f_o == (z_o[ZW-1] != $past(in_angle[AW-1]))))
    else $error("fold flag does not match the half-turn move"); // R4

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
  import cordic_rot_pkg::*;
#(
  parameter int IW  = 24,
  parameter int ZW  = 22,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_i,
  input  logic                 f_i,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 v_o,
  output logic                 f_o,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  localparam logic signed [ZW-1:0] STEP = ZW'(atan_code(IDX, ZW));

  logic signed [IW-1:0] x_sh, y_sh, x_n, y_n;
  logic signed [ZW-1:0] z_n;

  // Fixed shift distance: pure wiring.
  assign x_sh = x_i >>> IDX;
  assign y_sh = y_i >>> IDX;

  always_comb begin
    if (!z_i[ZW-1]) begin
      x_n = x_i - y_sh;
      y_n = y_i + x_sh;
      z_n = z_i - STEP;
    end else begin
      x_n = x_i + y_sh;
      y_n = y_i - x_sh;
      z_n = z_i + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    f_o <= f_i;
    x_o <= x_n;
    y_o <= y_n;
    z_o <= z_n;
  end

  AST_RESIDUAL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (zabs(longint'(z_o)) <= zabs(longint'($past(z_i))) ||
             zabs(longint'(z_o)) <= longint'(STEP)))
    else $error("residual angle grew in stage %0d", IDX); // R3

endmodule

// File: rtl/cordic_fix.sv
module cordic_fix #(
  parameter int IW = 24,
  parameter int OW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_i,
  input  logic                 f_i,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  output logic                 v_o,
  output logic signed [OW-1:0] x_o,
  output logic signed [OW-1:0] y_o
);
  localparam int G = IW - OW;
  localparam logic signed [IW-1:0] HALF = IW'(1) << (G - 1);
  localparam logic signed [IW-1:0] LIM  = IW'(1) << (OW - 1);

  logic signed [IW-1:0] x_r, y_r;
  logic signed [OW-1:0] x_s, y_s;

  always_comb begin
    x_r = (x_i + HALF) >>> G;
    y_r = (y_i + HALF) >>> G;
    x_s = f_i ? -x_r[OW-1:0] : x_r[OW-1:0];
    y_s = f_i ? -y_r[OW-1:0] : y_r[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    x_o <= x_s;
    y_o <= y_s;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    v_i |-> (x_r < LIM && x_r > -LIM && y_r < LIM && y_r > -LIM))
    else $error("rounded result does not fit the output width"); // R8

endmodule

// File: rtl/cordic_rot_pipe.sv
module cordic_rot_pipe
  import cordic_rot_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 16,
  parameter int STAGES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_x,
  input  logic signed [DW-1:0] in_y,
  input  logic        [AW-1:0] in_angle,
  output logic                 out_valid,
  output logic signed [DW+1:0] out_x,
  output logic signed [DW+1:0] out_y
);
  localparam int GB      = guard_bits(STAGES);
  localparam int OW      = DW + 2;
  localparam int IW      = OW + GB;
  localparam int ZW      = AW + GB;
  localparam int LATENCY = STAGES + 2;
  localparam longint TAIL = longint'(atan_code(STAGES - 1, ZW)) + STAGES;

  logic                 v_s [STAGES+1];
  logic                 f_s [STAGES+1];
  logic signed [IW-1:0] x_s [STAGES+1];
  logic signed [IW-1:0] y_s [STAGES+1];
  logic signed [ZW-1:0] z_s [STAGES+1];

  cordic_fold #(.DW(DW), .AW(AW), .IW(IW), .ZW(ZW)) u_fold (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_angle(in_angle), .v_o(v_s[0]), .f_o(f_s[0]), .x_o(x_s[0]),
    .y_o(y_s[0]), .z_o(z_s[0])
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_iter
    cordic_stage #(.IW(IW), .ZW(ZW), .IDX(k)) u_stage (
      .clk(clk), .rst(rst),
      .v_i(v_s[k]), .f_i(f_s[k]), .x_i(x_s[k]), .y_i(y_s[k]), .z_i(z_s[k]),
      .v_o(v_s[k+1]), .f_o(f_s[k+1]), .x_o(x_s[k+1]), .y_o(y_s[k+1]),
      .z_o(z_s[k+1])
    );
  end

  cordic_fix #(.IW(IW), .OW(OW)) u_fix (
    .clk(clk), .rst(rst), .v_i(v_s[STAGES]), .f_i(f_s[STAGES]),
    .x_i(x_s[STAGES]), .y_i(y_s[STAGES]),
    .v_o(out_valid), .x_o(out_x), .y_o(out_y)
  );

  AST_RESIDUAL_SMALL: assert property (@(posedge clk) disable iff (rst)
    v_s[STAGES] |-> zabs(longint'(z_s[STAGES])) <= TAIL)
    else $error("angle not driven to zero after %0d stages of %0d", STAGES, LATENCY); // R3

  AST_RESET_FLUSH: assert property (@(posedge clk)
    rst |=> !out_valid)
    else $error("result valid right after reset"); // R6

endmodule

// File: tb/test_cordic_rot_pipe.sv
module test_cordic_rot_pipe;
  localparam int DW = 12, AW = 14, STAGES = 14;
  localparam int OW = DW + 2, LAT = STAGES + 2;
  localparam real TURN = 6.283185307179586;

  logic                 clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [DW-1:0] in_x = '0, in_y = '0;
  logic        [AW-1:0] in_angle = '0;
  logic                 out_valid;
  logic signed [OW-1:0] out_x, out_y;

  always #2 clk = ~clk;  // 250 MHz

  cordic_rot_pipe #(.DW(DW), .AW(AW), .STAGES(STAGES)) i_cordic_rot_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_angle(in_angle), .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
  );

  int  total = 0, bad = 0, cyc = 0;
  bit  rst_seen = 1'b1;
  bit  qv[$];
  real qx[$], qy[$];
  string qt[$];
  real gain;

  always @(posedge clk) begin
    rst_seen <= rst;
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual cycles=%0d expected < 20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check_out();
    bit ev; real ex, ey, dx, dy; string tg;
    if (rst_seen) begin
      total++;
      if (out_valid !== 1'b0) begin
        bad++;
        $display("FAIL R6: out_valid after reset edge actual=%b expected=0", out_valid);
      end
      qv.delete(); qx.delete(); qy.delete(); qt.delete();
      for (int i = 0; i < LAT - 1; i++) begin
        qv.push_back(1'b0); qx.push_back(0.0); qy.push_back(0.0); qt.push_back("R6");
      end
      return;
    end
    ev = qv.pop_front(); ex = qx.pop_front(); ey = qy.pop_front(); tg = qt.pop_front();
    total++;
    if (!ev) begin
      if (out_valid !== 1'b0) begin
        bad++;
        $display("FAIL %s (bubble, R7): out_valid actual=%b expected=0", tg, out_valid);
      end
    end else if (out_valid !== 1'b1) begin
      bad++;
      $display("FAIL R1 (%s): out_valid actual=%b expected=1", tg, out_valid);
    end else begin
      dx = real'(out_x) - ex;
      dy = real'(out_y) - ey;
      if (dx > 2.0 || dx < -2.0 || dy > 2.0 || dy < -2.0) begin
        bad++;
        $display("FAIL %s: actual=(%0d,%0d) expected=(%0.2f,%0.2f)", tg, out_x, out_y, ex, ey);
      end
    end
  endtask

  task automatic step(input bit r, input bit v, input int x, input int y,
                      input int a, input string tag);
    real t, xr, yr;
    @(negedge clk);
    check_out();
    rst      = r;
    in_valid = v;
    in_x     = DW'(x);
    in_y     = DW'(y);
    in_angle = AW'(a);
    t  = real'($signed(in_angle)) * TURN / (2.0 ** AW);
    xr = real'($signed(in_x));
    yr = real'($signed(in_y));
    qv.push_back(v);
    qx.push_back(gain * (xr * $cos(t) - yr * $sin(t)));
    qy.push_back(gain * (xr * $sin(t) + yr * $cos(t)));
    qt.push_back(v ? tag : "R7");
  endtask

  initial begin
    int seed_x;
    int edges[9];
    int cx[4], cy[4], ca[3];
    gain = 1.0;
    for (int i = 0; i < STAGES; i++) gain = gain * $sqrt(1.0 + 2.0 ** (-2 * i));
    seed_x = $rtoi(2047.0 / gain + 0.5);

    // R6: reset state
    repeat (3) step(1'b1, 1'b0, 0, 0, 0, "R6");
    // R6: quiet for LATENCY cycles after reset
    repeat (LAT) step(1'b0, 1'b0, 0, 0, 0, "R6");

    // R5: cosine/sine sweep over a full turn, continuous stream (R2)
    for (int k = 0; k < 64; k++) step(1'b0, 1'b1, seed_x, 0, k * 256, "R5");

    // R4: quadrant boundary codes; 4096 = +90 deg, -8192 = -180 deg
    edges = '{0, 4096, 4095, 4097, -4096, -4097, -8192, 8191, 12288};
    foreach (edges[i]) step(1'b0, 1'b1, 1500, -700, edges[i], "R4");
    foreach (edges[i]) step(1'b0, 1'b1, seed_x, 0, edges[i], "R4");

    // R8: full-scale corner vectors
    cx = '{-2048, 2047, -2048, 2047};
    cy = '{-2048, 2047, 2047, -2048};
    ca = '{2048, -6144, 6144};
    foreach (cx[i]) foreach (ca[j]) step(1'b0, 1'b1, cx[i], cy[i], ca[j], "R8");

    // R3 with random bubbles (R7)
    for (int k = 0; k < 200; k++)
      step(1'b0, ($urandom_range(0, 3) != 0),
           int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048,
           int'($urandom_range(0, 16383)), "R3");

    // R2: unbroken random stream
    for (int k = 0; k < 40; k++)
      step(1'b0, 1'b1, int'($urandom_range(0, 4095)) - 2048,
           int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 16383)), "R2");

    // R6: reset in mid-stream drops samples in flight
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 900, 300, k * 1000, "R6");
    repeat (2) step(1'b1, 1'b1, 900, 300, 0, "R6");
    repeat (LAT) step(1'b0, 1'b0, 0, 0, 0, "R6");

    // R1: latency and order after the reset
    for (int k = 0; k < 20; k++) step(1'b0, 1'b1, 100 * k - 1000, 50 * k, 700 * k, "R1");

    repeat (LAT + 2) step(1'b0, 1'b0, 0, 0, 0, "R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule